// File: doc/BRIEF.md
# ECC Error Status and Counter Unit

This block gathers the error reports that the SECDED checkers of two SRAM banks raise. Each bank delivers a one-cycle pulse for a single-bit error that was corrected and another for a double-bit error that could not be corrected, along with the word address that failed. For every bank and every error type the block keeps three things. The first is a sticky status flag. The second is a 16-bit event counter that saturates. The third is the address of the latest event of that type. An interrupt line is raised while any status flag is set.

Software reaches the block through a small word-addressed register port. Writes take effect at the clock edge. Reads are combinational from the current address. Four registers can be written: the status register, which clears on writing a one; a counter-clear register, which acts only as a strobe; the status-update enable register; and the per-bank checking enable. Four more registers are read-only and return the counters and the captured addresses. The encoder and the decoder sit outside the block.

Top module: `eccmon_unit`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: Register map by `regAddr`: 0 status, 1 counter clear, 2 status-update enable, 3 checking enable, 4 and 5 the counter words of bank 0 and bank 1, 6 and 7 the address words of bank 0 and bank 1. Event slot `2*b` is the single-bit error of bank `b` and slot `2*b+1` is the double-bit error of bank `b`; the status, clear and update-enable registers use these slot positions in bits [3:0]. The checking enable holds bank `b` in bit `b`.
- R3: Each counter word places the double-bit count in bits [31:16] and the single-bit count in bits [15:0]. A counter goes up by one for each event that its bank's checking enable lets through.
- R4: A counter at 0xFFFF stays at 0xFFFF on further events and never wraps.
- R5: Writing 1 to a bit of the clear register zeroes that counter half one edge later. The clear register always reads 0. When a clear and an event hit the same counter in the same cycle, the counter ends at 0.
- R6: A status bit is set by an enabled event when its update-enable bit is 1. Writing 1 to a status bit clears only that bit. An event in the same cycle as the clear leaves the bit set.
- R7: When an update-enable bit is 0, the event leaves its status bit unchanged, but the event is still counted and its address is still captured.
- R8: When a bank's checking enable is 0, its error inputs change no counter, no address and no status bit of that bank.
- R9: Each address word holds the last double-bit error address in bits [25:13] and the last single-bit error address in bits [12:0]. Bits [31:26] read 0, and a newer event overwrites the older address.
- R10: `irq` is 1 exactly when at least one status bit is set.
- R11: Writes to registers 4 to 7 have no effect. The two enable registers read back what was written to them, limited to their defined bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `regAddr` (combinational) |
| sglErr | input | 2 | Per-bank corrected single-bit error pulse |
| dblErr | input | 2 | Per-bank uncorrectable double-bit error pulse |
| errAddr | input | 26 | Failing word address; bank `b` in bits [13*b+12:13*b] |
| irq | output | 1 | OR of all status bits |

## Verification
Isolated pulses on a single slot show whether the counter, status and address fields land in the right slot and bit position. Repeating the same slot with new addresses separates last-wins capture from first-wins capture. Holding one error input high for more than 65,535 cycles checks that the counter saturates rather than wraps. Same-cycle collisions between an event and a clear check both priority rules. Switching the update enable and the checking enable off separately separates "count but do not flag" from "ignore entirely". A seeded random phase then mixes events on all slots with arbitrary writes to every register address, including the read-only ones, and compares all readable state against a bench model.

// File: rtl/eccmon_pkg.sv
`timescale 1ns/1ps
package eccmon_pkg;
  parameter int NUM_BANKS = 2;
  parameter int ADDR_W    = 13;
  parameter int CNT_W     = 16;
  parameter int DATA_W    = 32;
  parameter int REG_AW    = 3;
  localparam int EVT_W    = 2 * NUM_BANKS;
  localparam int ENC_PAD  = DATA_W - 2 * ADDR_W;
  localparam int CNT_PAD  = DATA_W - 2 * CNT_W;

  typedef enum logic [REG_AW-1:0] {
    RA_STATUS = 3'd0,
    RA_CLEAR  = 3'd1,
    RA_UPDEN  = 3'd2,
    RA_ECCEN  = 3'd3,
    RA_CNT0   = 3'd4,
    RA_CNT1   = 3'd5,
    RA_ADR0   = 3'd6,
    RA_ADR1   = 3'd7
  } regAddr_e;

  typedef struct packed {
    logic [EVT_W-1:0] w1c;
    logic [EVT_W-1:0] clr;
    logic [EVT_W-1:0] logEvt;
    logic [EVT_W-1:0] flagEvt;
  } ctlStrobe_t;
endpackage

// File: rtl/eccmon_ctrl.sv
`timescale 1ns/1ps
module eccmon_ctrl
  import eccmon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [EVT_W-1:0]     wrBits,
  input  logic [EVT_W-1:0]     evtRaw,
  output ctlStrobe_t           strobes,
  output logic [EVT_W-1:0]     updEnQ,
  output logic [NUM_BANKS-1:0] eccEnQ
);
  logic wrStatus, wrClear, wrUpd, wrEcc;

  assign wrStatus = wrEn && (regAddr == RA_STATUS);
  assign wrClear  = wrEn && (regAddr == RA_CLEAR);
  assign wrUpd    = wrEn && (regAddr == RA_UPDEN);
  assign wrEcc    = wrEn && (regAddr == RA_ECCEN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updEnQ <= '0;
      eccEnQ <= '0;
    end else begin
      if (wrUpd) updEnQ <= wrBits;
      if (wrEcc) eccEnQ <= wrBits[NUM_BANKS-1:0];
    end
  end

  always_comb begin
    strobes.w1c = wrStatus ? wrBits : '0;
    strobes.clr = wrClear  ? wrBits : '0;
    for (int i = 0; i < EVT_W; i++) begin
      strobes.logEvt[i]  = evtRaw[i] & eccEnQ[i/2];
      strobes.flagEvt[i] = evtRaw[i] & eccEnQ[i/2] & updEnQ[i];
    end
  end
endmodule

// File: rtl/eccmon_dp.sv
`timescale 1ns/1ps
module eccmon_dp
  import eccmon_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  ctlStrobe_t                         strobes,
  input  logic [NUM_BANKS*ADDR_W-1:0]        errAddr,
  output logic [EVT_W-1:0][CNT_W-1:0]        cntQ,
  output logic [EVT_W-1:0][ADDR_W-1:0]       adrQ,
  output logic [EVT_W-1:0]                   stsQ
);
  for (genvar i = 0; i < EVT_W; i++) begin : g_slot
    localparam int BANK = i / 2;
    logic atMax;
    assign atMax = &cntQ[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ[i] <= '0;
        adrQ[i] <= '0;
        stsQ[i] <= 1'b0;
      end else begin
        if (strobes.clr[i])
          cntQ[i] <= '0;
        else if (strobes.logEvt[i] && !atMax)
          cntQ[i] <= cntQ[i] + 1'b1;
        if (strobes.logEvt[i])
          adrQ[i] <= errAddr[BANK*ADDR_W +: ADDR_W];
        stsQ[i] <= strobes.flagEvt[i] | (stsQ[i] & ~strobes.w1c[i]);
      end
    end
  end
endmodule

// File: rtl/eccmon_unit.sv
`timescale 1ns/1ps
module eccmon_unit
  import eccmon_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [REG_AW-1:0]             regAddr,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             rdData,
  input  logic [NUM_BANKS-1:0]          sglErr,
  input  logic [NUM_BANKS-1:0]          dblErr,
  input  logic [NUM_BANKS*ADDR_W-1:0]   errAddr,
  output logic                          irq
);
  ctlStrobe_t                    strobes;
  logic [EVT_W-1:0]              evtRaw;
  logic [EVT_W-1:0]              updEnQ;
  logic [NUM_BANKS-1:0]          eccEnQ;
  logic [EVT_W-1:0][CNT_W-1:0]   cntQ;
  logic [EVT_W-1:0][ADDR_W-1:0]  adrQ;
  logic [EVT_W-1:0]              stsQ;
  logic                          unusedWr;

  assign unusedWr = ^wrData[DATA_W-1:EVT_W];

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      evtRaw[2*b]   = sglErr[b];
      evtRaw[2*b+1] = dblErr[b];
    end
  end

  eccmon_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .wrBits(wrData[EVT_W-1:0]), .evtRaw(evtRaw),
    .strobes(strobes), .updEnQ(updEnQ), .eccEnQ(eccEnQ)
  );

  eccmon_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .errAddr(errAddr),
    .cntQ(cntQ), .adrQ(adrQ), .stsQ(stsQ)
  );

  assign irq = |stsQ;

  always_comb begin
    rdData = '0;
    case (regAddr_e'(regAddr))
      RA_STATUS: rdData[EVT_W-1:0]     = stsQ;
      RA_UPDEN:  rdData[EVT_W-1:0]     = updEnQ;
      RA_ECCEN:  rdData[NUM_BANKS-1:0] = eccEnQ;
      RA_CNT0:   rdData = {{CNT_PAD{1'b0}}, cntQ[1], cntQ[0]};
      RA_CNT1:   rdData = {{CNT_PAD{1'b0}}, cntQ[3], cntQ[2]};
      RA_ADR0:   rdData = {{ENC_PAD{1'b0}}, adrQ[1], adrQ[0]};
      RA_ADR1:   rdData = {{ENC_PAD{1'b0}}, adrQ[3], adrQ[2]};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/eccmon_chk.sv
`timescale 1ns/1ps
module eccmon_chk
  import eccmon_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic [EVT_W-1:0][CNT_W-1:0] cnt,
  input logic [EVT_W-1:0]            clr,
  input logic [EVT_W-1:0]            logEvt,
  input logic [EVT_W-1:0]            flagEvt,
  input logic [EVT_W-1:0]            w1c,
  input logic [EVT_W-1:0]            sts
);
  for (genvar i = 0; i < EVT_W; i++) begin : g_chk
    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
      (logEvt[i] && !clr[i] && !(&cnt[i])) |=> cnt[i] == CNT_W'($past(cnt[i]) + 1'b1));
    a_r4_hold_max: assert property (@(posedge clk) disable iff (!rstN)
      ((&cnt[i]) && !clr[i]) |=> (&cnt[i]));
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
      clr[i] |=> cnt[i] == '0);
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      flagEvt[i] |=> sts[i]);
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
      (w1c[i] && !flagEvt[i]) |=> !sts[i]);
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
      (!logEvt[i] && !clr[i]) |=> $stable(cnt[i]));
  end
endmodule

bind eccmon_unit eccmon_chk u_chk (
  .clk(clk), .rstN(rstN), .cnt(cntQ), .clr(strobes.clr),
  .logEvt(strobes.logEvt), .flagEvt(strobes.flagEvt),
  .w1c(strobes.w1c), .sts(stsQ)
);

// File: tb/eccmon_unit_bench.sv
`timescale 1ns/1ps
module eccmon_unit_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [2:0]  regAddr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic [1:0]  sglErr, dblErr;
  logic [25:0] errAddr;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;

  logic [15:0] mCnt [4];
  logic [12:0] mAdr [4];
  logic [3:0]  mSts, mUpd;
  logic [1:0]  mEcc;

  always #4 clk = ~clk;

  eccmon_unit u_eccmon_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .sglErr(sglErr), .dblErr(dblErr), .errAddr(errAddr), .irq(irq)
  );

  function automatic logic [31:0] expWord(input int ra);
    case (ra)
      0: return {28'd0, mSts};
      2: return {28'd0, mUpd};
      3: return {30'd0, mEcc};
      4: return {mCnt[1], mCnt[0]};
      5: return {mCnt[3], mCnt[2]};
      6: return {6'd0, mAdr[1], mAdr[0]};
      7: return {6'd0, mAdr[3], mAdr[2]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic idle();
    wrEn = 1'b0; regAddr = 3'd0; wrData = '0; sglErr = '0; dblErr = '0; errAddr = '0;
  endtask

  // one clock: drive at a falling edge, advance the model, wait for the next falling edge
  task automatic cycle(input logic [3:0] evt, input logic [12:0] a0, input logic [12:0] a1,
                       input logic wr, input logic [2:0] wa, input logic [31:0] wd);
    logic [3:0] nSts;
    sglErr = {evt[2], evt[0]};
    dblErr = {evt[3], evt[1]};
    errAddr = {a1, a0};
    wrEn = wr; regAddr = wa; wrData = wd;
    for (int i = 0; i < 4; i++) begin
      logic ev, clr, w1c;
      ev  = evt[i] & mEcc[i/2];
      clr = wr && wa == 3'd1 && wd[i];
      w1c = wr && wa == 3'd0 && wd[i];
      if (clr) mCnt[i] = 16'd0;
      else if (ev && mCnt[i] != 16'hFFFF) mCnt[i] = mCnt[i] + 16'd1;
      if (ev) mAdr[i] = (i < 2) ? a0 : a1;
      nSts[i] = (ev & mUpd[i]) | (mSts[i] & ~w1c);
    end
    mSts = nSts;
    if (wr && wa == 3'd2) mUpd = wd[3:0];
    if (wr && wa == 3'd3) mEcc = wd[1:0];
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] wa, input logic [31:0] wd);
    cycle(4'd0, 13'd0, 13'd0, 1'b1, wa, wd);
  endtask

  task automatic compareAll(input string tag);
    idle();
    for (int ra = 0; ra < 8; ra++) begin
      regAddr = 3'(ra);
      #0.4;
      vectors++;
      if (rdData !== expWord(ra)) begin
        miscompares++;
        $display("FAIL %s reg=%0d actual=%h expected=%h", tag, ra, rdData, expWord(ra));
      end
    end
    vectors++;
    if (irq !== (|mSts)) begin
      miscompares++;
      $display("FAIL %s (R10 irq) actual=%b expected=%b", tag, irq, |mSts);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin mCnt[i] = '0; mAdr[i] = '0; end
    mSts = '0; mUpd = '0; mEcc = '0;
    idle();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 reset");

    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    compareAll("R11 enable readback");

    cycle(4'b0001, 13'h123, 13'h0, 1'b0, 3'd0, 0);
    compareAll("R2 R3 R6 R9 bank0 single");
    cycle(4'b1000, 13'h0, 13'h1ABC, 1'b0, 3'd0, 0);
    compareAll("R3 R9 bank1 double");
    cycle(4'b0001, 13'h0AA, 13'h0, 1'b0, 3'd0, 0);
    compareAll("R9 last address wins");

    wr(3'd2, 32'hE);
    wr(3'd0, 32'h1);
    compareAll("R6 w1c single bit");
    cycle(4'b0001, 13'h055, 13'h0, 1'b0, 3'd0, 0);
    compareAll("R7 update disabled still counts");

    wr(3'd3, 32'h1);
    cycle(4'b1100, 13'h0, 13'h0FF, 1'b0, 3'd0, 0);
    compareAll("R8 bank1 checking off");

    wr(3'd3, 32'h3);
    wr(3'd2, 32'hF);
    cycle(4'b0010, 13'h321, 13'h0, 1'b1, 3'd0, 32'h2);
    compareAll("R6 event beats w1c");
    cycle(4'b0010, 13'h322, 13'h0, 1'b1, 3'd1, 32'h2);
    compareAll("R5 clear beats event");

    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    compareAll("R11 read-only writes ignored");

    wr(3'd0, 32'hF);
    compareAll("R10 all status cleared");

    for (int k = 0; k < 65540; k++) cycle(4'b0100, 13'h0, 13'h0777, 1'b0, 3'd0, 0);
    compareAll("R4 saturation");
    cycle(4'b0100, 13'h0, 13'h0778, 1'b0, 3'd0, 0);
    compareAll("R4 stays at max");
    wr(3'd1, 32'h4);
    compareAll("R5 clear after saturation");

    for (int k = 0; k < 3000; k++) begin
      logic [3:0] evt;
      logic doWr;
      evt  = 4'($urandom) & 4'($urandom);
      doWr = ($urandom % 4) == 0;
      cycle(evt, 13'($urandom), 13'($urandom), doWr, 3'($urandom), $urandom);
      if (k % 16 == 15) compareAll("R3 R5 R6 R8 R9 random");
    end
    compareAll("R2 R11 final");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule